// File: doc/BRIEF.md
# AXI Burst Latency Profiler

This block sits beside one AXI4 memory master and watches its read and write channels without driving any of them. For every burst it times three phases: from the address handshake to the first data beat (which includes arbitration and interconnect delay), from the first data beat to the beat marked last, and from the last write beat to the write response handshake. Reads have no response phase, so they add zero to that sum. At completion, each burst adds its three phase times, its byte count and a count of one to five per-interval counters.

A host samples the profiler periodically by pulsing `sample_i`. The pulse copies the counters into a set of snapshot outputs and starts a new interval. The host divides each latency sum by the burst count to get an average. Counters saturate at their maximum instead of wrapping. Each counter has a sticky overflow bit that marks the interval in which it saturated. Outstanding bursts are timed through small in-order queues of request timestamps, one queue for reads and one for writes, so bursts that overlap are each timed from their own request.

Top module: `axi_lat_profiler`

## Requirements
- R1: During and after reset, with no sample taken yet, every snapshot output is zero and `smp_valid_o` is low.
- R2: A burst's address-phase time is the number of clock edges from its address handshake (valid and ready both high) to its first data handshake. Cycles in which valid is high but ready is low do not count as transfers.
- R3: A burst's data-phase time is the number of edges from its first data handshake to the handshake with the last flag set. It is zero for a single-beat burst.
- R4: A write burst's response-phase time is the number of edges from its last W handshake to its B handshake. A read burst always adds zero to this sum.
- R5: A read burst completes on its last R handshake, and a write burst completes on its B handshake. At completion, the burst adds 1 to the burst counter and (len+1)×DATA_BYTES to the byte counter, and adds its three phase times to their sums.
- R6: Up to DEPTH bursts may be outstanding in each direction. Data beats are matched in order to accepted addresses, so each burst is timed from its own address handshake.
- R7: A read completion and a write completion in the same cycle are both counted.
- R8: A sample pulse latches the counter values from before that cycle's completions into the snapshot outputs. The new interval starts holding only that cycle's completions. `smp_valid_o` pulses high for one cycle, in the cycle after the pulse, and the snapshot holds its value until the next pulse.
- R9: Each counter stops at 2^CNT_W−1. Its overflow bit is set when the counter reaches that value, stays set for the rest of the interval, and is reported in `smp_ovf_o` at the next sample. The bits are: 0 bytes, 1 bursts, 2 address phase, 3 data phase, 4 response phase.
- R10: `master_id_o` always reports the MASTER_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ar_valid_i | input | 1 | Observed read address valid |
| ar_ready_i | input | 1 | Observed read address ready |
| ar_len_i | input | LEN_W | Observed read burst length minus one |
| r_valid_i | input | 1 | Observed read data valid |
| r_ready_i | input | 1 | Observed read data ready |
| r_last_i | input | 1 | Observed read last beat |
| aw_valid_i | input | 1 | Observed write address valid |
| aw_ready_i | input | 1 | Observed write address ready |
| aw_len_i | input | LEN_W | Observed write burst length minus one |
| w_valid_i | input | 1 | Observed write data valid |
| w_ready_i | input | 1 | Observed write data ready |
| w_last_i | input | 1 | Observed write last beat |
| b_valid_i | input | 1 | Observed write response valid |
| b_ready_i | input | 1 | Observed write response ready |
| sample_i | input | 1 | Latch the snapshot and restart the interval |
| master_id_o | output | ID_W | Identifier of the observed master |
| smp_valid_o | output | 1 | One-cycle pulse after a sample |
| smp_bytes_o | output | CNT_W | Bytes moved in the last interval |
| smp_bursts_o | output | CNT_W | Bursts completed in the last interval |
| smp_lat_addr_o | output | CNT_W | Sum of address-phase times |
| smp_lat_data_o | output | CNT_W | Sum of data-phase times |
| smp_lat_resp_o | output | CNT_W | Sum of response-phase times |
| smp_ovf_o | output | 5 | Sticky saturation bits for the last interval |

## Verification
The bench sweeps burst length, address delay, gaps between beats and write response delay. This catches an off-by-one phase boundary, which would show up as every sum being wrong by the burst count. Two addresses accepted back to back before any data would expose a single timestamp register, because the second burst would be timed from the wrong request. A read and a write finishing in the same cycle would expose an adder that takes one increment and loses the other. A sample that lands on a completing burst would show whether that burst is dropped or counted twice. Long bursts saturate the byte counter, which would show whether the counter wraps and whether the overflow bit is cleared when the next interval starts.

// File: rtl/lat_prof_pkg.sv
package lat_prof_pkg;
  localparam int unsigned CI_BYTES  = 0;
  localparam int unsigned CI_BURSTS = 1;
  localparam int unsigned CI_ADDR   = 2;
  localparam int unsigned CI_DATA   = 3;
  localparam int unsigned CI_RESP   = 4;
  localparam int unsigned NUM_CNT   = 5;
endpackage

// File: rtl/lat_fifo.sv
module lat_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0] occ_q;
  logic             do_push, do_pop;

  assign full_o  = (occ_q == OCC_W'(DEPTH));
  assign empty_o = (occ_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/lat_beat_tracker.sv
module lat_beat_tracker #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] now_i,
  input  logic [TS_W-1:0] head_ts_i,
  input  logic            beat_i,
  input  logic            last_i,
  output logic            done_o,
  output logic [TS_W-1:0] addr_lat_o,
  output logic [TS_W-1:0] data_lat_o
);
  logic            in_burst_q;
  logic [TS_W-1:0] first_ts_q, addr_lat_q;

  assign done_o     = beat_i && last_i;
  assign addr_lat_o = in_burst_q ? addr_lat_q : (now_i - head_ts_i);
  assign data_lat_o = in_burst_q ? (now_i - first_ts_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_burst_q <= 1'b0;
      first_ts_q <= '0;
      addr_lat_q <= '0;
    end else if (beat_i) begin
      in_burst_q <= !last_i;
      if (!in_burst_q) begin
        first_ts_q <= now_i;
        addr_lat_q <= now_i - head_ts_i;
      end
    end
  end
endmodule

// File: rtl/lat_sat_acc.sv
module lat_sat_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] inc_a_i,
  input  logic [W-1:0] inc_b_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W+1:0] LIMIT = {2'b00, {W{1'b1}}};

  logic [W-1:0] base;
  logic [W+1:0] sum;
  logic         hit;

  assign base = clr_i ? '0 : cnt_o;
  assign sum  = {2'b00, base} + {2'b00, inc_a_i} + {2'b00, inc_b_i};
  assign hit  = (sum >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      cnt_o <= hit ? LIMIT[W-1:0] : sum[W-1:0];
      ovf_o <= (ovf_o && !clr_i) || hit;
    end
  end
endmodule

// File: rtl/axi_lat_profiler.sv
module axi_lat_profiler
  import lat_prof_pkg::*;
#(
  parameter int unsigned MASTER_ID  = 0,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned TS_W       = 16,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DEPTH      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ar_valid_i,
  input  logic             ar_ready_i,
  input  logic [LEN_W-1:0] ar_len_i,
  input  logic             r_valid_i,
  input  logic             r_ready_i,
  input  logic             r_last_i,
  input  logic             aw_valid_i,
  input  logic             aw_ready_i,
  input  logic [LEN_W-1:0] aw_len_i,
  input  logic             w_valid_i,
  input  logic             w_ready_i,
  input  logic             w_last_i,
  input  logic             b_valid_i,
  input  logic             b_ready_i,
  input  logic             sample_i,
  output logic [ID_W-1:0]  master_id_o,
  output logic             smp_valid_o,
  output logic [CNT_W-1:0] smp_bytes_o,
  output logic [CNT_W-1:0] smp_bursts_o,
  output logic [CNT_W-1:0] smp_lat_addr_o,
  output logic [CNT_W-1:0] smp_lat_data_o,
  output logic [CNT_W-1:0] smp_lat_resp_o,
  output logic [4:0]       smp_ovf_o
);
  localparam int unsigned AQ_W = TS_W + LEN_W;
  localparam int unsigned BQ_W = 3 * TS_W + LEN_W;

  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  // read side
  logic             rd_push, rd_full, rd_empty, rd_beat, rd_done;
  logic [AQ_W-1:0]  rd_head;
  logic [TS_W-1:0]  rd_alat, rd_dlat;

  assign rd_push = ar_valid_i && ar_ready_i;
  assign rd_beat = r_valid_i && r_ready_i;

  lat_fifo #(.W(AQ_W), .DEPTH(DEPTH)) rd_q_i (
    .clk_i, .rst_ni, .push_i(rd_push), .data_i({ts_q, ar_len_i}),
    .pop_i(rd_done), .data_o(rd_head), .full_o(rd_full), .empty_o(rd_empty)
  );

  lat_beat_tracker #(.TS_W(TS_W)) rd_trk_i (
    .clk_i, .rst_ni, .now_i(ts_q), .head_ts_i(rd_head[AQ_W-1:LEN_W]),
    .beat_i(rd_beat), .last_i(r_last_i), .done_o(rd_done),
    .addr_lat_o(rd_alat), .data_lat_o(rd_dlat)
  );

  // write side: address queue then response queue
  logic             aw_push, aw_full, aw_empty, w_beat, w_done;
  logic [AQ_W-1:0]  aw_head;
  logic [TS_W-1:0]  w_alat, w_dlat;
  logic             b_hs, b_full, b_empty, b_done;
  logic [BQ_W-1:0]  b_head;

  assign aw_push = aw_valid_i && aw_ready_i;
  assign w_beat  = w_valid_i && w_ready_i;
  assign b_hs    = b_valid_i && b_ready_i;
  assign b_done  = b_hs && !b_empty;

  lat_fifo #(.W(AQ_W), .DEPTH(DEPTH)) aw_q_i (
    .clk_i, .rst_ni, .push_i(aw_push), .data_i({ts_q, aw_len_i}),
    .pop_i(w_done), .data_o(aw_head), .full_o(aw_full), .empty_o(aw_empty)
  );

  lat_beat_tracker #(.TS_W(TS_W)) w_trk_i (
    .clk_i, .rst_ni, .now_i(ts_q), .head_ts_i(aw_head[AQ_W-1:LEN_W]),
    .beat_i(w_beat), .last_i(w_last_i), .done_o(w_done),
    .addr_lat_o(w_alat), .data_lat_o(w_dlat)
  );

  lat_fifo #(.W(BQ_W), .DEPTH(DEPTH)) b_q_i (
    .clk_i, .rst_ni, .push_i(w_done),
    .data_i({w_alat, w_dlat, ts_q, aw_head[LEN_W-1:0]}),
    .pop_i(b_hs), .data_o(b_head), .full_o(b_full), .empty_o(b_empty)
  );

  logic [TS_W-1:0]  b_alat, b_dlat, b_last_ts, b_rlat;
  logic [LEN_W-1:0] b_len;
  assign {b_alat, b_dlat, b_last_ts, b_len} = b_head;
  assign b_rlat = ts_q - b_last_ts;

  // per-interval counters
  logic [CNT_W-1:0] inc_rd [NUM_CNT];
  logic [CNT_W-1:0] inc_wr [NUM_CNT];
  logic [CNT_W-1:0] cnt    [NUM_CNT];
  logic [CNT_W-1:0] snap_q [NUM_CNT];
  logic [NUM_CNT-1:0] ovf;
  logic [NUM_CNT-1:0] snap_ovf_q;

  always_comb begin
    for (int i = 0; i < int'(NUM_CNT); i++) begin
      inc_rd[i] = '0;
      inc_wr[i] = '0;
    end
    if (rd_done) begin
      inc_rd[CI_BYTES]  = CNT_W'({1'b0, rd_head[LEN_W-1:0]} + 1'b1) * CNT_W'(DATA_BYTES);
      inc_rd[CI_BURSTS] = CNT_W'(1);
      inc_rd[CI_ADDR]   = CNT_W'(rd_alat);
      inc_rd[CI_DATA]   = CNT_W'(rd_dlat);
    end
    if (b_done) begin
      inc_wr[CI_BYTES]  = CNT_W'({1'b0, b_len} + 1'b1) * CNT_W'(DATA_BYTES);
      inc_wr[CI_BURSTS] = CNT_W'(1);
      inc_wr[CI_ADDR]   = CNT_W'(b_alat);
      inc_wr[CI_DATA]   = CNT_W'(b_dlat);
      inc_wr[CI_RESP]   = CNT_W'(b_rlat);
    end
  end

  for (genvar g = 0; g < int'(NUM_CNT); g++) begin : g_acc
    lat_sat_acc #(.W(CNT_W)) acc_i (
      .clk_i, .rst_ni, .clr_i(sample_i),
      .inc_a_i(inc_rd[g]), .inc_b_i(inc_wr[g]),
      .cnt_o(cnt[g]), .ovf_o(ovf[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       snap_q[g] <= '0;
      else if (sample_i) snap_q[g] <= cnt[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_ovf_q  <= '0;
      smp_valid_o <= 1'b0;
    end else begin
      smp_valid_o <= sample_i;
      if (sample_i) snap_ovf_q <= ovf;
    end
  end

  assign master_id_o    = ID_W'(MASTER_ID);
  assign smp_bytes_o    = snap_q[CI_BYTES];
  assign smp_bursts_o   = snap_q[CI_BURSTS];
  assign smp_lat_addr_o = snap_q[CI_ADDR];
  assign smp_lat_data_o = snap_q[CI_DATA];
  assign smp_lat_resp_o = snap_q[CI_RESP];
  assign smp_ovf_o      = snap_ovf_q;
endmodule

// File: rtl/axi_lat_profiler_chk.sv
module axi_lat_profiler_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_i,
  input logic             smp_valid_o,
  input logic [CNT_W-1:0] smp_bytes_o,
  input logic [CNT_W-1:0] smp_bursts_o,
  input logic [4:0]       smp_ovf_o,
  input logic             rd_push_i,
  input logic             rd_full_i,
  input logic             aw_push_i,
  input logic             aw_full_i,
  input logic             w_done_i,
  input logic             b_full_i
);
  AST_SAMPLE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> smp_valid_o); // R8
  AST_VALID_ONLY_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> !smp_valid_o); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(smp_bytes_o) && $stable(smp_bursts_o)); // R8
  AST_BYTES_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ovf_o[0] |-> (smp_bytes_o == {CNT_W{1'b1}})); // R9
  AST_BURSTS_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ovf_o[1] |-> (smp_bursts_o == {CNT_W{1'b1}})); // R9
  AST_RD_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_push_i |-> !rd_full_i); // R6
  AST_WR_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_push_i |-> !aw_full_i); // R6
  AST_RESP_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_done_i |-> !b_full_i); // R6
endmodule

bind axi_lat_profiler axi_lat_profiler_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .smp_valid_o (smp_valid_o),
  .smp_bytes_o (smp_bytes_o),
  .smp_bursts_o(smp_bursts_o),
  .smp_ovf_o   (smp_ovf_o),
  .rd_push_i   (rd_push),
  .rd_full_i   (rd_full),
  .aw_push_i   (aw_push),
  .aw_full_i   (aw_full),
  .w_done_i    (w_done),
  .b_full_i    (b_full)
);

// File: tb/axi_lat_profiler_tb.sv
module axi_lat_profiler_tb_top;
  localparam int unsigned DB    = 4;
  localparam int unsigned CW    = 12;
  localparam int unsigned LW    = 8;
  localparam int unsigned MID   = 5;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0, sample = 0;
  logic [LW-1:0] ar_len = '0, aw_len = '0;
  logic [3:0]    mid;
  logic          smp_valid;
  logic [CW-1:0] s_bytes, s_bursts, s_addr, s_data, s_resp;
  logic [4:0]    s_ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  axi_lat_profiler #(
    .MASTER_ID(MID), .ID_W(4), .DATA_BYTES(DB), .LEN_W(LW),
    .TS_W(10), .CNT_W(CW), .DEPTH(4)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ar_valid_i(ar_valid), .ar_ready_i(ar_ready), .ar_len_i(ar_len),
    .r_valid_i(r_valid), .r_ready_i(r_ready), .r_last_i(r_last),
    .aw_valid_i(aw_valid), .aw_ready_i(aw_ready), .aw_len_i(aw_len),
    .w_valid_i(w_valid), .w_ready_i(w_ready), .w_last_i(w_last),
    .b_valid_i(b_valid), .b_ready_i(b_ready), .sample_i(sample),
    .master_id_o(mid), .smp_valid_o(smp_valid),
    .smp_bytes_o(s_bytes), .smp_bursts_o(s_bursts),
    .smp_lat_addr_o(s_addr), .smp_lat_data_o(s_data), .smp_lat_resp_o(s_resp),
    .smp_ovf_o(s_ovf)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd_burst(input int len, input int d1, input int gap);
    ar_valid = 1; ar_ready = 1; ar_len = LW'(len);
    @(posedge clk); @(negedge clk);
    ar_valid = 0; ar_ready = 0;
    repeat (d1 - 1) @(negedge clk);
    for (int b = 0; b <= len; b++) begin
      r_valid = 1; r_ready = 1; r_last = (b == len);
      @(posedge clk); @(negedge clk);
      r_valid = 0; r_ready = 0; r_last = 0;
      if (b < len) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wr_burst(input int len, input int d1, input int gap, input int d3);
    aw_valid = 1; aw_ready = 1; aw_len = LW'(len);
    @(posedge clk); @(negedge clk);
    aw_valid = 0; aw_ready = 0;
    repeat (d1 - 1) @(negedge clk);
    for (int b = 0; b <= len; b++) begin
      w_valid = 1; w_ready = 1; w_last = (b == len);
      @(posedge clk); @(negedge clk);
      w_valid = 0; w_ready = 0; w_last = 0;
      if (b < len) repeat (gap) @(negedge clk);
    end
    repeat (d3 - 1) @(negedge clk);
    b_valid = 1; b_ready = 1;
    @(posedge clk); @(negedge clk);
    b_valid = 0; b_ready = 0;
  endtask

  task automatic pulse_sample();
    sample = 1;
    @(posedge clk); @(negedge clk);
    sample = 0;
  endtask

  task automatic sample_chk(input string req, input int by, input int bu,
                            input int la, input int ld, input int lr, input int ov);
    pulse_sample();
    chk({req, " R8 valid"}, int'(smp_valid), 1);
    chk({req, " R5 bytes"}, int'(s_bytes), by);
    chk({req, " R5 bursts"}, int'(s_bursts), bu);
    chk({req, " R2 addr"}, int'(s_addr), la);
    chk({req, " R3 data"}, int'(s_data), ld);
    chk({req, " R4 resp"}, int'(s_resp), lr);
    chk({req, " R9 ovf"}, int'(s_ovf), ov);
    @(negedge clk);
    chk({req, " R8 valid drop"}, int'(smp_valid), 0);
  endtask

  initial begin
    int lens[4] = '{0, 1, 3, 7};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(smp_valid), 0);
    chk("R1 bytes", int'(s_bytes), 0);
    chk("R1 bursts", int'(s_bursts), 0);
    chk("R1 ovf", int'(s_ovf), 0);
    chk("R10 id", int'(mid), MID);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'(s_addr) + int'(s_data) + int'(s_resp), 0);

    // R2 R3 R5: read sweep
    for (int li = 0; li < 4; li++)
      for (int d1 = 1; d1 <= 5; d1 += 2)
        for (int gap = 0; gap <= 1; gap++) begin
          rd_burst(lens[li], d1, gap);
          sample_chk("rd sweep", (lens[li] + 1) * DB, 1, d1, lens[li] * (gap + 1), 0, 0);
        end

    // R4 R5: write sweep
    for (int li = 0; li < 4; li++)
      for (int d1 = 1; d1 <= 3; d1 += 2)
        for (int d3 = 1; d3 <= 4; d3 += 3) begin
          wr_burst(lens[li], d1, 1, d3);
          sample_chk("wr sweep", (lens[li] + 1) * DB, 1, d1, lens[li] * 2, d3, 0);
        end

    // R8 empty interval clears
    sample_chk("empty interval", 0, 0, 0, 0, 0, 0);

    // R5 accumulation over several bursts
    rd_burst(1, 2, 0);
    rd_burst(2, 1, 1);
    wr_burst(0, 3, 0, 2);
    sample_chk("accumulate", 2 * DB + 3 * DB + DB, 3, 2 + 1 + 3, 1 + 4, 2, 0);

    // R2: stalled address and data handshakes do not count
    ar_valid = 1; ar_len = '0;
    repeat (3) @(negedge clk);
    ar_ready = 1;
    @(posedge clk); @(negedge clk);
    ar_valid = 0; ar_ready = 0;
    r_valid = 1; r_last = 1;
    @(negedge clk);
    r_ready = 1;
    @(posedge clk); @(negedge clk);
    r_valid = 0; r_ready = 0; r_last = 0;
    sample_chk("R2 stall", DB, 1, 2, 0, 0, 0);

    // R6: two reads outstanding
    ar_valid = 1; ar_ready = 1; ar_len = 8'd1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    ar_valid = 0; ar_ready = 0;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      r_valid = 1; r_ready = 1; r_last = (b % 2 == 1);
      @(posedge clk); @(negedge clk);
    end
    r_valid = 0; r_ready = 0; r_last = 0;
    sample_chk("R6 overlap", 4 * DB, 2, 3 + 4, 2, 0, 0);

    // R7: read and write complete in the same cycle
    fork
      rd_burst(0, 2, 0);
      wr_burst(0, 1, 0, 1);
    join
    sample_chk("R7 same cycle", 2 * DB, 2, 3, 0, 1, 0);

    // R8: completion coincident with sample goes to the new interval
    fork
      rd_burst(0, 3, 0);
      begin
        repeat (3) @(negedge clk);
        pulse_sample();
      end
    join
    chk("R8 coincident excluded", int'(s_bursts), 0);
    sample_chk("R8 coincident carried", DB, 1, 3, 0, 0, 0);

    // R9: byte counter saturates and the flag clears next interval
    for (int k = 0; k < 4; k++) rd_burst(255, 1, 0);
    sample_chk("R9 saturate", int'(MAXV), 4, 4, 4 * 255, 0, 1);
    sample_chk("R9 cleared", 0, 0, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule